// File: doc/BRIEF.md
# Factory Bad Block Scanner

This controller runs one survey of a raw NAND array before the first program or erase reaches it. After a start pulse it visits every erase block in ascending order. For each block it asks a page-operation sequencer for one byte: the first spare-area byte of the block's first page, then the same byte of its second page. Each read starts directly at that spare column, so no page data area is transferred. If either byte differs from FFh, the block is recorded as carrying the factory invalid marker.

The outcome is held in a one-bit-per-block bitmap, where 1 means bad, and in a count of bad blocks. A block index can be presented to read the bitmap back one bit at a time once the scan is done. A warning output flags a result that breaks the shipment guarantees: block 0 found bad, or more bad blocks than the allowed maximum. The scan has to be finished before anything erases the array, because an erase wipes the marker for good.

Top module: `bad_block_scanner`

## Requirements
- R1: After reset, `busy`, `done`, `warn`, `map_bad` and `rd_req_valid` are 0 and `bad_count` is 0.
- R2: A `start` pulse while `busy` is low raises `busy` on the next cycle, clears `done` and resets `bad_count` to 0. A `start` while `busy` is high is ignored: the scan in progress neither restarts nor changes.
- R3: Requests come in the order block 0 page 0, block 0 page 1, block 1 page 0, and so on up to the last block. `rd_row` = block*PAGES + page, `rd_col` is always MARK_COL (2048 by default), and exactly 2*NUM_BLOCKS requests are issued per scan.
- R4: While `rd_req_valid` is high and `rd_req_ready` is low, `rd_req_valid`, `rd_row` and `rd_col` hold their values.
- R5: A block is bad when the byte returned for its page 0 or its page 1 is not 8'hFF, and good when both are 8'hFF. Its bitmap bit holds 1 for bad and 0 for good.
- R6: When `done` is high, `bad_count` equals the number of bad blocks found by the last scan.
- R7: `done` rises on the cycle after the response for the last block's page 1 is accepted, in the same cycle that `busy` falls. The two are never high together.
- R8: `map_bad` shows the bitmap bit of the block that `map_idx` selected on the previous clock edge. It reads 0 whenever `done` was low at that edge.
- R9: `warn` is high exactly when `done` is high and either `bad_count` > MAX_BAD or block 0 is bad.
- R10: A new scan replaces every bitmap bit and the count, so results from an earlier scan leave no trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a scan while idle |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished, results valid |
| warn | output | 1 | Block 0 bad or count above MAX_BAD |
| bad_count | output | CNT_W | Number of bad blocks |
| rd_req_valid | output | 1 | Single-byte read request to the sequencer |
| rd_req_ready | input | 1 | Sequencer accepts the request |
| rd_row | output | ROW_W | Page row address of the request |
| rd_col | output | COL_W | Column address of the request |
| rsp_valid | input | 1 | Returned byte is valid |
| rsp_byte | input | 8 | Returned marker byte |
| map_idx | input | BLK_W | Block index for bitmap read |
| map_bad | output | 1 | Bitmap bit of the block selected one cycle earlier |

## Verification
If the page flag or the block index is corrupted, the request stream shows it at once: the next `rd_row` is out of sequence, and the bench compares every accepted request with its arithmetic prediction. A mishandled per-block verdict stays hidden until the scan ends. It then appears in `bad_count`, in `warn` and in the one-cycle bitmap read-back, which the bench sweeps over every block of a small configuration for several marker patterns. Those patterns cover a lone bad page 0, a lone bad page 1, both pages bad, block 0 bad, a count just at and just above the limit, and every block bad.

// File: rtl/bad_block_scanner.sv
module bad_block_scanner #(
  parameter int NUM_BLOCKS = 4096,
  parameter int PAGES      = 64,
  parameter int COL_W      = 12,
  parameter int MARK_COL   = 2048,
  parameter int MAX_BAD    = 80,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int ROW_W = $clog2(NUM_BLOCKS * PAGES),
  localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             warn,
  output logic [CNT_W-1:0] bad_count,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [ROW_W-1:0] rd_row,
  output logic [COL_W-1:0] rd_col,
  input  logic             rsp_valid,
  input  logic [7:0]       rsp_byte,
  input  logic [BLK_W-1:0] map_idx,
  output logic             map_bad
);
  localparam logic [BLK_W-1:0] LAST = BLK_W'(NUM_BLOCKS - 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;
  st_t st;

  logic [BLK_W-1:0]      blk;
  logic                  pg;
  logic                  hit;
  logic                  blk0_bad;
  logic [NUM_BLOCKS-1:0] bad_map;

  wire byte_bad = rsp_byte != 8'hFF;
  wire blk_bad  = hit | byte_bad;
  wire take     = st == S_WAIT && rsp_valid;

  assign busy         = st != S_IDLE;
  assign rd_req_valid = st == S_REQ;
  assign rd_row       = ROW_W'(blk) * ROW_W'(PAGES) + ROW_W'(pg);
  assign rd_col       = COL_W'(MARK_COL);
  assign warn         = done && (bad_count > CNT_W'(MAX_BAD) || blk0_bad);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      blk       <= '0;
      pg        <= 1'b0;
      hit       <= 1'b0;
      blk0_bad  <= 1'b0;
      bad_count <= '0;
      done      <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st        <= S_REQ;
          blk       <= '0;
          pg        <= 1'b0;
          hit       <= 1'b0;
          blk0_bad  <= 1'b0;
          bad_count <= '0;
          done      <= 1'b0;
        end
        S_REQ: if (rd_req_ready) st <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          if (!pg) begin
            pg  <= 1'b1;
            hit <= byte_bad;
            st  <= S_REQ;
          end else begin
            pg        <= 1'b0;
            hit       <= 1'b0;
            bad_count <= bad_count + CNT_W'(blk_bad);
            if (blk == '0) blk0_bad <= blk_bad;
            if (blk == LAST) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else begin
              blk <= blk + 1'b1;
              st  <= S_REQ;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (take && pg) bad_map[blk] <= blk_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_bad <= 1'b0;
    else        map_bad <= done & bad_map[map_idx];
  end
endmodule

// File: rtl/bad_block_scanner_chk.sv
module bad_block_scanner_chk #(
  parameter int NUM_BLOCKS = 4096,
  parameter int PAGES      = 64,
  parameter int COL_W      = 12,
  parameter int MARK_COL   = 2048,
  parameter int ROW_W      = 18,
  parameter int CNT_W      = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             warn,
  input logic [CNT_W-1:0] bad_count,
  input logic             rd_req_valid,
  input logic             rd_req_ready,
  input logic [ROW_W-1:0] rd_row,
  input logic [COL_W-1:0] rd_col,
  input logic             map_bad
);
  assert_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done && bad_count == '0));

  assert_req_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> busy);

  assert_marker_col_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (int'(rd_col) == MARK_COL));

  assert_first_two_pages_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> ((int'(rd_row) % PAGES) <= 1));

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_row) && $stable(rd_col)));

  assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

  assert_done_busy_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  assert_map_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> !map_bad);

  assert_warn_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    warn |-> done);
endmodule

bind bad_block_scanner bad_block_scanner_chk #(
  .NUM_BLOCKS(NUM_BLOCKS), .PAGES(PAGES), .COL_W(COL_W),
  .MARK_COL(MARK_COL), .ROW_W(ROW_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .warn(warn), .bad_count(bad_count), .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready), .rd_row(rd_row), .rd_col(rd_col),
  .map_bad(map_bad)
);

// File: tb/bad_block_scanner_test.sv
`timescale 1ns/1ps
module bad_block_scanner_test;
  localparam int NB = 16, PG = 4, CW = 12, MC = 2048, MAXB = 3;
  localparam int BW = $clog2(NB), RW = $clog2(NB * PG), KW = $clog2(NB + 1);

  logic clk = 0, rst_n = 0, start = 0;
  logic busy, done, warn, rd_req_valid, map_bad;
  logic rd_req_ready = 0, rsp_valid = 0;
  logic [7:0] rsp_byte = 8'hFF;
  logic [KW-1:0] bad_count;
  logic [RW-1:0] rd_row;
  logic [CW-1:0] rd_col;
  logic [BW-1:0] map_idx = '0;

  bad_block_scanner #(.NUM_BLOCKS(NB), .PAGES(PG), .COL_W(CW), .MARK_COL(MC), .MAX_BAD(MAXB)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .warn(warn),
    .bad_count(bad_count), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_row(rd_row), .rd_col(rd_col), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
    .map_idx(map_idx), .map_bad(map_bad));

  always #2.5 clk = ~clk;

  int total = 0, fails = 0;
  int sel = 0, k = 0, order_err = 0, pend = 0, prow = 0;
  logic [7:0] lfsr = 8'h5A;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mark(input int s, input int b, input int p);
    case (s)
      1: begin
        if (b == 3 && p == 0) return 8'h00;
        if (b == 7 && p == 1) return 8'hFE;
        if (b == 10) return 8'h7F;
      end
      2: if (b == 0 && p == 1) return 8'h7F;
      3: if (b % 4 == 1 && p == 0) return 8'hF0;
      4: if (p == 0) return 8'h00;
      default: ;
    endcase
    return 8'hFF;
  endfunction

  function automatic bit blk_bad(input int s, input int b);
    return mark(s, b, 0) != 8'hFF || mark(s, b, 1) != 8'hFF;
  endfunction

  // sequencer model
  always @(negedge clk) begin
    rsp_valid = 0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        rsp_valid = 1;
        rsp_byte  = mark(sel, prow / PG, prow % PG);
      end
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rd_req_ready = lfsr[1] | lfsr[4];
    if (rd_req_valid && rd_req_ready) begin
      if (int'(rd_row) != (k / 2) * PG + (k % 2) || int'(rd_col) != MC) begin
        order_err++;
        $display("  request %0d: row=%0d col=%0d", k, rd_row, rd_col);
      end
      prow = int'(rd_row);
      pend = 1 + k % 3;
      k++;
    end
  end

  task automatic run_scan(input int s, input bit poke);
    int exp_cnt, g;
    bit exp_warn;
    sel = s; k = 0; order_err = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy && !done && bad_count == 0, "R2 start", {busy, done}, 2);
    map_idx = '0;
    @(negedge clk);
    chk(map_bad == 0, "R8 gated while busy", map_bad, 0);
    if (poke) begin
      repeat (7) @(negedge clk);
      start = 1; @(negedge clk); start = 0;   // R2: ignored while busy
    end
    g = 0;
    while (!done && g < 5000) begin @(negedge clk); g++; end
    chk(done && !busy, "R7 done/busy", {done, busy}, 2);
    exp_cnt = 0;
    for (int b = 0; b < NB; b++) exp_cnt += blk_bad(s, b);
    exp_warn = exp_cnt > MAXB || blk_bad(s, 0);
    chk(bad_count == exp_cnt, "R6 count", bad_count, exp_cnt);
    chk(warn == exp_warn, "R9 warn", warn, exp_warn);
    chk(order_err == 0 && k == 2 * NB, "R3 order/requests", k, 2 * NB);
    for (int b = 0; b < NB; b++) begin
      map_idx = BW'(b);
      @(negedge clk);
      chk(map_bad == blk_bad(s, b), "R5 R10 bitmap", map_bad, blk_bad(s, b));
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !warn && !map_bad && !rd_req_valid && bad_count == 0,
        "R1 reset", {busy, done, warn}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !rd_req_valid, "R1 after release", busy, 0);
    run_scan(1, 1'b1);
    run_scan(0, 1'b0);
    run_scan(2, 1'b0);
    run_scan(3, 1'b0);
    run_scan(4, 1'b0);
    run_scan(1, 1'b0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule